// File: doc/BRIEF.md
# Processor Exception Entry Unit

This unit performs the entry half of exception handling for a 32-bit processor core. When the pipeline signals an exception with an index, or when an external interrupt is pending and enabled, the unit saves the faulting PC in the right return register. It records the old global enable in the matching saved-enable bit, then clears the global enable. It also produces the handler address for the fetch stage. The interrupt-enable bits and both return registers are held in the unit. The two vector bases and the remap control arrive as inputs from the core's control registers.

Exceptions come in two groups. The ordinary group is bus errors, divide by zero, the system call and the external interrupt. It uses its own return register and saved-enable bit, and it vectors from the ordinary base unless remapping sends it to the debug base. The debug group is breakpoint and watchpoint. It uses a second return register and saved-enable bit and always vectors from the debug base. A system call can optionally be completed in place by an external handler, and then the PC only steps forward by one word. A separate combinational path folds the upper half of the physical address space onto the lower half when mirroring is enabled, and it marks the lower half as cacheable.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is applied and until the first request after it, `pc_load_o` and `err_o` are 0, and `ea_o`, `ba_o`, `pc_next_o` and `ie_o` are all zero.
- R2: A handler address is the selected base with its low 8 bits cleared, OR the 3-bit index placed in bits 7:5; bits 4:0 are zero.
- R3: An ordinary request (index 2 instruction bus error, 4 data bus error, 5 divide by zero, 7 system call) with `remap_i`=0 sets `ea_o` to `pc_i`, copies the global enable `ie_o[0]` into `ie_o[1]`, clears `ie_o[0]`, and vectors from `eba_i`.
- R4: With `remap_i`=1, an ordinary exception vectors from `deba_i` instead of `eba_i`.
- R5: A debug request (index 1 breakpoint, 3 watchpoint) sets `ba_o` to `pc_i`, copies `ie_o[0]` into `ie_o[2]`, clears `ie_o[0]`, and vectors from `deba_i` whatever `remap_i` is.
- R6: An interrupt (`irq_i`) is taken as an ordinary exception with index 6, but only when `ie_o[0]`=1 and no request is valid in that cycle. Otherwise it has no effect and stays pending for as long as `irq_i` is held.
- R7: With in-place system calls enabled, a request with index 7 and `sc_done_i`=1 loads `pc_i`+4 and leaves `ea_o`, `ba_o` and `ie_o` unchanged.
- R8: A request with an undefined index (0 or 6) pulses `err_o` for one cycle. It raises no `pc_load_o` and leaves `ea_o`, `ba_o`, `ie_o` and `pc_next_o` unchanged.
- R9: Every state update from one entry commits at the same clock edge after the request, and `pc_load_o` is a single-cycle pulse.
- R10: In a cycle with no request and no taken interrupt, `ie_wr_i` loads `ie_o` from `ie_wdata_i`, where bit 0 is the global enable, bit 1 the ordinary saved enable and bit 2 the debug saved enable. In any other cycle the write is ignored.
- R11: `phys_o` equals `addr_i` with bit 31 cleared when `mirror_en_i`=1 and equals `addr_i` otherwise. `cacheable_o` is 1 exactly when bit 31 of `addr_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Exception request present |
| req_idx_i | input | 3 | Exception index of the request |
| pc_i | input | 32 | PC of the excepting instruction |
| eba_i | input | 32 | Ordinary vector base |
| deba_i | input | 32 | Debug vector base |
| remap_i | input | 1 | Send ordinary exceptions to the debug base |
| irq_i | input | 1 | External interrupt pending |
| sc_done_i | input | 1 | System call completed in place |
| ie_wr_i | input | 1 | Write strobe for the enable bits |
| ie_wdata_i | input | 3 | Enable bits to write {debug saved, ordinary saved, global} |
| addr_i | input | 32 | Physical address to translate |
| mirror_en_i | input | 1 | Fold the upper half onto the lower half |
| pc_load_o | output | 1 | One-cycle strobe: fetch from pc_next_o |
| pc_next_o | output | 32 | Handler address or advanced PC |
| ea_o | output | 32 | Ordinary return register |
| ba_o | output | 32 | Debug return register |
| ie_o | output | 3 | {debug saved, ordinary saved, global} enable |
| err_o | output | 1 | One-cycle strobe: undefined index |
| phys_o | output | 32 | Translated physical address |
| cacheable_o | output | 1 | Address lies in the cacheable half |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, a 32-byte vector stride and in-place system calls enabled. With these values both the handled and the unhandled system call paths can be reached, and so can an unaligned base whose low byte must be dropped. Requests are made to coincide with interrupts and with enable writes so that the priority order is exercised. The remap control is toggled against both exception groups.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int EXC_IDX_W = 3;

  typedef enum logic [1:0] {
    CLS_ORD = 2'd0,
    CLS_DBG = 2'd1,
    CLS_BAD = 2'd2
  } exc_class_e;

  localparam logic [EXC_IDX_W-1:0] IDX_BREAK   = 3'd1;
  localparam logic [EXC_IDX_W-1:0] IDX_IBUS    = 3'd2;
  localparam logic [EXC_IDX_W-1:0] IDX_WATCH   = 3'd3;
  localparam logic [EXC_IDX_W-1:0] IDX_DBUS    = 3'd4;
  localparam logic [EXC_IDX_W-1:0] IDX_DIVZ    = 3'd5;
  localparam logic [EXC_IDX_W-1:0] IDX_IRQ     = 3'd6;
  localparam logic [EXC_IDX_W-1:0] IDX_SYSCALL = 3'd7;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
(
  input  logic [EXC_IDX_W-1:0] idx_i,
  output exc_class_e           cls_o
);
  // Index 6 belongs to the interrupt input only; a request carrying it is illegal.
  always_comb begin
    unique case (idx_i)
      IDX_BREAK, IDX_WATCH:                   cls_o = CLS_DBG;
      IDX_IBUS, IDX_DBUS, IDX_DIVZ, IDX_SYSCALL: cls_o = CLS_ORD;
      default:                                cls_o = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SHIFT = 5
) (
  input  logic [AW-1:0]        base_i,
  input  logic [EXC_IDX_W-1:0] idx_i,
  output logic [AW-1:0]        vec_o
);
  localparam int ALIGN = EXC_IDX_W + SHIFT;
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << ALIGN) - 64'd1);

  always_comb begin
    vec_o = (base_i & ~LOW_MASK) | (AW'(idx_i) << SHIFT);
  end
endmodule

// File: rtl/addr_mirror.sv
module addr_mirror #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          mirror_en_i,
  output logic [AW-1:0] phys_o,
  output logic          cacheable_o
);
  localparam logic [AW-1:0] TOP_BIT = AW'(1) << (AW - 1);

  always_comb begin
    phys_o      = mirror_en_i ? (addr_i & ~TOP_BIT) : addr_i;
    cacheable_o = ~addr_i[AW-1];
  end

  always_comb begin
    if (mirror_en_i === 1'b1) begin
      assert_mirror_top_clear_R11: assert (phys_o[AW-1] == 1'b0);
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SHIFT      = 5,
  parameter bit SC_INPLACE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid_i,
  input  logic [EXC_IDX_W-1:0] req_idx_i,
  input  logic [AW-1:0]        pc_i,
  input  logic [AW-1:0]        eba_i,
  input  logic [AW-1:0]        deba_i,
  input  logic                 remap_i,
  input  logic                 irq_i,
  input  logic                 sc_done_i,
  input  logic                 ie_wr_i,
  input  logic [2:0]           ie_wdata_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 mirror_en_i,
  output logic                 pc_load_o,
  output logic [AW-1:0]        pc_next_o,
  output logic [AW-1:0]        ea_o,
  output logic [AW-1:0]        ba_o,
  output logic [2:0]           ie_o,
  output logic                 err_o,
  output logic [AW-1:0]        phys_o,
  output logic                 cacheable_o
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ok = rst_pipe_q[1];

  // decode
  exc_class_e           cls;
  logic                 sc_local, irq_take, do_err, do_dbg, do_ord, entry;
  logic [EXC_IDX_W-1:0] eff_idx;
  logic [AW-1:0]        base_sel, vec;

  exc_classify u_cls (.idx_i(req_idx_i), .cls_o(cls));

  generate
    if (SC_INPLACE) begin : g_sc
      assign sc_local = req_valid_i && (req_idx_i == IDX_SYSCALL) && sc_done_i;
    end else begin : g_no_sc
      assign sc_local = 1'b0;
    end
  endgenerate

  logic ie_q, eie_q, bie_q;

  always_comb begin
    irq_take = !req_valid_i && irq_i && ie_q;
    do_err   = req_valid_i && (cls == CLS_BAD);
    do_dbg   = req_valid_i && (cls == CLS_DBG);
    do_ord   = (req_valid_i && (cls == CLS_ORD) && !sc_local) || irq_take;
    entry    = do_dbg || do_ord;
    eff_idx  = req_valid_i ? req_idx_i : IDX_IRQ;
    base_sel = (do_dbg || remap_i) ? deba_i : eba_i;
  end

  exc_vector #(.AW(AW), .SHIFT(SHIFT)) u_vec (
    .base_i(base_sel), .idx_i(eff_idx), .vec_o(vec)
  );

  // next state
  logic          ie_d, eie_d, bie_d, ie_en;
  logic [AW-1:0] ea_d, ba_d, pcn_d;
  logic          ea_en, ba_en, pcn_en, load_d, err_d;

  always_comb begin
    ie_d   = ie_q;
    eie_d  = eie_q;
    bie_d  = bie_q;
    ie_en  = 1'b0;
    ea_d   = pc_i;
    ba_d   = pc_i;
    ea_en  = 1'b0;
    ba_en  = 1'b0;
    pcn_d  = vec;
    pcn_en = 1'b0;
    load_d = 1'b0;
    err_d  = do_err;
    if (do_dbg) begin
      ba_en  = 1'b1;
      bie_d  = ie_q;
      ie_d   = 1'b0;
      ie_en  = 1'b1;
      pcn_en = 1'b1;
      load_d = 1'b1;
    end else if (do_ord) begin
      ea_en  = 1'b1;
      eie_d  = ie_q;
      ie_d   = 1'b0;
      ie_en  = 1'b1;
      pcn_en = 1'b1;
      load_d = 1'b1;
    end else if (sc_local) begin
      pcn_d  = pc_i + WORD_STEP;
      pcn_en = 1'b1;
      load_d = 1'b1;
    end else if (!req_valid_i && ie_wr_i) begin
      {bie_d, eie_d, ie_d} = ie_wdata_i;
      ie_en  = 1'b1;
    end
  end

  // registers
  logic [AW-1:0] ea_q, ba_q, pcn_q;
  logic          load_q, err_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ie_q   <= 1'b0;
      eie_q  <= 1'b0;
      bie_q  <= 1'b0;
      ea_q   <= '0;
      ba_q   <= '0;
      pcn_q  <= '0;
      load_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ie_en) begin
        ie_q  <= ie_d;
        eie_q <= eie_d;
        bie_q <= bie_d;
      end
      if (ea_en)  ea_q  <= ea_d;
      if (ba_en)  ba_q  <= ba_d;
      if (pcn_en) pcn_q <= pcn_d;
      load_q <= load_d;
      err_q  <= err_d;
    end
  end

  assign pc_load_o = load_q;
  assign pc_next_o = pcn_q;
  assign ea_o      = ea_q;
  assign ba_o      = ba_q;
  assign ie_o      = {bie_q, eie_q, ie_q};
  assign err_o     = err_q;

  addr_mirror #(.AW(AW)) u_mirror (
    .addr_i(addr_i), .mirror_en_i(mirror_en_i),
    .phys_o(phys_o), .cacheable_o(cacheable_o)
  );

  // checks
  assert_ord_entry_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid_i && (req_idx_i inside {3'd2, 3'd4, 3'd5}))
      |=> (ea_o == $past(pc_i)) && !ie_o[0] && (ie_o[1] == $past(ie_o[0])) && pc_load_o);

  assert_dbg_entry_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid_i && (req_idx_i inside {3'd1, 3'd3}))
      |=> (ba_o == $past(pc_i)) && !ie_o[0] && (ie_o[2] == $past(ie_o[0])) && $stable(ea_o));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (!req_valid_i && irq_i && !ie_o[0]) |=> !pc_load_o && $stable(ea_o));

  assert_bad_idx_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid_i && (req_idx_i inside {3'd0, 3'd6}))
      |=> err_o && !pc_load_o && $stable(ie_o) && $stable(ea_o) && $stable(ba_o) && $stable(pc_next_o));

  assert_vec_align_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (pc_load_o && !$stable(ie_o[0])) |-> (pc_next_o[SHIFT-1:0] == '0));

  assert_load_pulse_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !(pc_load_o && err_o));
endmodule

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, irq, remap, sc_done, ie_wr, mirror_en;
  logic [2:0]  req_idx, ie_wdata;
  logic [31:0] pc, eba, deba, addr;
  logic        pc_load, err, cacheable;
  logic [31:0] pc_next, ea, ba, phys;
  logic [2:0]  ie;

  exc_entry_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_idx_i(req_idx),
    .pc_i(pc), .eba_i(eba), .deba_i(deba), .remap_i(remap), .irq_i(irq),
    .sc_done_i(sc_done), .ie_wr_i(ie_wr), .ie_wdata_i(ie_wdata),
    .addr_i(addr), .mirror_en_i(mirror_en), .pc_load_o(pc_load),
    .pc_next_o(pc_next), .ea_o(ea), .ba_o(ba), .ie_o(ie), .err_o(err),
    .phys_o(phys), .cacheable_o(cacheable)
  );

  typedef struct {
    string       tag;
    logic        load, err, cach;
    logic [31:0] nxt, ea, ba, phys;
    logic [2:0]  ie;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;

  // reference state
  logic        m_ie, m_eie, m_bie;
  logic [31:0] m_ea, m_ba, m_nxt;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] vec_of(logic [31:0] b, logic [2:0] i);
    return {b[31:8], i, 5'b0};
  endfunction

  task automatic step(string tag, logic rv, logic [2:0] ix, logic [31:0] p,
                      logic [31:0] eb, logic [31:0] db, logic rm, logic iq,
                      logic scd, logic iw, logic [2:0] iwd,
                      logic [31:0] ad, logic me);
    exp_t e;
    @(negedge clk);
    req_valid = rv; req_idx = ix; pc = p; eba = eb; deba = db; remap = rm;
    irq = iq; sc_done = scd; ie_wr = iw; ie_wdata = iwd; addr = ad; mirror_en = me;
    e.tag = tag; e.load = 1'b0; e.err = 1'b0;
    if (rv) begin
      if (ix == 3'd0 || ix == 3'd6) e.err = 1'b1;
      else if (ix == 3'd7 && scd) begin e.load = 1'b1; m_nxt = p + 32'd4; end
      else if (ix == 3'd1 || ix == 3'd3) begin
        m_ba = p; m_bie = m_ie; m_ie = 1'b0; m_nxt = vec_of(db, ix); e.load = 1'b1;
      end else begin
        m_ea = p; m_eie = m_ie; m_ie = 1'b0; m_nxt = vec_of(rm ? db : eb, ix); e.load = 1'b1;
      end
    end else if (iq && m_ie) begin
      m_ea = p; m_eie = m_ie; m_ie = 1'b0; m_nxt = vec_of(rm ? db : eb, 3'd6); e.load = 1'b1;
    end else if (iw) begin
      {m_bie, m_eie, m_ie} = iwd;
    end
    e.nxt = m_nxt; e.ea = m_ea; e.ba = m_ba; e.ie = {m_bie, m_eie, m_ie};
    e.phys = me ? {1'b0, ad[30:0]} : ad;
    e.cach = ~ad[31];
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 3'd0, 32'h0, 32'h0, 32'h0, 0, 0, 0, 0, 3'd0, 32'h0, 0);
  endtask

  task automatic chk(string tag, string nm, logic [31:0] a, logic [31:0] x);
    checks++;
    if (a !== x) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, a, x);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "pc_load", {31'b0, pc_load}, {31'b0, e.load});
      chk(e.tag, "err", {31'b0, err}, {31'b0, e.err});
      chk(e.tag, "pc_next", pc_next, e.nxt);
      chk(e.tag, "ea", ea, e.ea);
      chk(e.tag, "ba", ba, e.ba);
      chk(e.tag, "ie", {29'b0, ie}, {29'b0, e.ie});
      chk(e.tag, "phys", phys, e.phys);
      chk(e.tag, "cacheable", {31'b0, cacheable}, {31'b0, e.cach});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_idx = 0; pc = 0; eba = 0; deba = 0; remap = 0; irq = 0;
    sc_done = 0; ie_wr = 0; ie_wdata = 0; addr = 0; mirror_en = 0;
    m_ie = 0; m_eie = 0; m_bie = 0; m_ea = 0; m_ba = 0; m_nxt = 0;
    // R1: reset state, also while stray inputs toggle
    repeat (3) idle("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) idle("R1");
    // R10: enable write
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b001, 32'h0, 0);
    // R6: enabled interrupt taken with index 6
    step("R6", 0, 0, 32'h0000_0100, 32'h1000_0000, 32'h2000_0000, 0, 1, 0, 0, 0, 32'h0, 0);
    idle("R9");
    // R6: interrupt held while disabled: no effect
    step("R6", 0, 0, 32'h0000_0200, 32'h1000_0000, 32'h2000_0000, 0, 1, 0, 0, 0, 32'h0, 0);
    step("R6", 0, 0, 32'h0000_0204, 32'h1000_0000, 32'h2000_0000, 0, 1, 0, 0, 0, 32'h0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b001, 32'h0, 0);
    // R3: ordinary entry from eba
    step("R3", 1, 3'd2, 32'h0000_0040, 32'h1000_0000, 32'h2000_0000, 0, 0, 0, 0, 0, 32'h0, 0);
    // R4: remapped ordinary entry from deba
    step("R4", 1, 3'd5, 32'h0000_0044, 32'h1000_0000, 32'h2000_0100, 1, 0, 0, 0, 0, 32'h0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b011, 32'h0, 0);
    // R5: debug entries, remap off then on
    step("R5", 1, 3'd1, 32'h0000_0080, 32'h1000_0000, 32'h3000_0000, 0, 0, 0, 0, 0, 32'h0, 0);
    step("R5", 1, 3'd3, 32'h0000_0084, 32'h1000_0000, 32'h3000_0000, 1, 0, 0, 0, 0, 32'h0, 0);
    // R2: unaligned base low byte dropped
    step("R2", 1, 3'd4, 32'h0000_0090, 32'h1234_56FF, 32'h0, 0, 0, 0, 0, 0, 32'h0, 0);
    // R7: in-place system call, then unhandled one
    step("R7", 1, 3'd7, 32'h0000_0800, 32'h1000_0000, 32'h2000_0000, 0, 0, 1, 0, 0, 32'h0, 0);
    step("R3", 1, 3'd7, 32'h0000_0900, 32'h1000_0000, 32'h2000_0000, 0, 0, 0, 0, 0, 32'h0, 0);
    // R8: undefined indices, one with a concurrent enable write that must be ignored
    step("R8", 1, 3'd0, 32'h0000_0A00, 32'h1000_0000, 32'h2000_0000, 0, 0, 0, 0, 0, 32'h0, 0);
    step("R8", 1, 3'd6, 32'h0000_0A04, 32'h1000_0000, 32'h2000_0000, 0, 1, 0, 1, 3'b111, 32'h0, 0);
    idle("R8");
    // R6: request wins over a simultaneous interrupt
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b001, 32'h0, 0);
    step("R6", 1, 3'd4, 32'h0000_0B00, 32'h4000_0000, 32'h2000_0000, 0, 1, 0, 0, 0, 32'h0, 0);
    step("R6", 0, 0, 32'h0000_0B04, 32'h4000_0000, 32'h2000_0000, 0, 1, 0, 0, 0, 32'h0, 0);
    // R10: write ignored alongside a request
    step("R10", 1, 3'd5, 32'h0000_0C00, 32'h4000_0000, 32'h2000_0000, 0, 0, 0, 1, 3'b111, 32'h0, 0);
    idle("R9");
    // R11: address mirroring
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h8000_1234, 1);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h8000_1234, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0000_0010, 1);
    idle("R9");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule